// File: doc/BRIEF.md
# Next-PC Unit with Conditional Skip

This block owns the program counter of a processor whose instructions are 16 bits wide and half-word aligned. Each cycle in which the decoder presents an instruction (`step_i`), the unit picks the address of the next instruction: the plain sequential successor, a PC-relative branch target built from an 11-bit signed offset, a register-indirect target, a return address taken from one of two fixed link registers, or a skip that jumps over the following instruction when a test passes. A skip passes over a prefix word and the instruction it qualifies as one unit, so the skip distance depends on whether the next half-word is a prefix.

Branch-to-subroutine and register call also produce a link value, stored in half-word units so that a later register jump (which shifts its operand left by one) lands just after the call and its delay slot. The link value is presented with a one-cycle write strobe for the register file.

Control is a two-state machine. `ST_BOOT` is the first cycle after reset: the PC holds the reset vector and `step_i` is ignored, giving fetch a cycle to issue the first request. Transition `boot_done` moves unconditionally to `ST_RUN`, where every presented instruction updates the PC. Reset from either state returns to `ST_BOOT`.

Top module: `npc_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` equals the reset vector with bit 0 cleared and `link_we_o` is 0; in the first clock edge after reset is released `step_i` is ignored and `pc_o` keeps the reset vector.
- R2: With control code 0 (sequential), or any code from 11 to 15, a step advances `pc_o` by 2; a cycle with `step_i` low leaves `pc_o` unchanged.
- R3: With control code 1 (branch), a step sets `pc_o` to `pc_o + ((sign-extended offset_i + 1) << 1)`, modulo 2^PC_W.
- R4: With control code 2 (branch-to-subroutine), the PC moves exactly as for code 1 and a link write is produced.
- R5: With control code 3 (register jump) or 4 (register call), a step sets `pc_o` to `rs_val_i << 1`; code 4 also produces a link write.
- R6: Control code 5 jumps to `olink_i << 1` and code 6 jumps to `ilink_i << 1`, neither producing a link write.
- R7: One cycle after a step with code 2 or 4, `link_we_o` is 1 for one cycle and `link_val_o` equals `(old pc_o + 4) >> 1`; `link_we_o` is 0 after any other cycle.
- R8: Skip codes: 7 skips when `rs_val_i` is zero, 8 when it is non-zero, 9 when `cc_true_i` is 1, 10 when it is 0. A taken skip advances the PC by 6 if `next_is_prefix_i` is 1 and by 4 otherwise; an untaken skip advances by 2.
- R9: Bit 0 of `pc_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | An instruction is presented this cycle |
| ctrl_i | input | 4 | Control code of the presented instruction |
| offset_i | input | 11 | Signed branch offset in half-words |
| rs_val_i | input | PC_W | Register operand (jump/call target, skip test) |
| olink_i | input | PC_W | Outgoing link register value |
| ilink_i | input | PC_W | Incoming link register value |
| cc_true_i | input | 1 | Result of the condition-code test |
| next_is_prefix_i | input | 1 | The half-word after the current one is a prefix |
| pc_o | output | PC_W | Current program counter |
| next_pc_o | output | PC_W | Address that the current step would load |
| link_we_o | output | 1 | Link register write strobe |
| link_val_o | output | PC_W | Link value in half-word units |

## Verification
The bench builds the unit with PC_W of 32 and a reset vector of 0x40, low enough that a maximal backward branch wraps below address zero and exercises the modulo behaviour of R3. A 32-bit width also lets a call target with bit 31 set show that the top bit is shifted out, and lets the link value of a call near the top of memory be checked. Back-to-back calls and idle cycles after a call bring the one-cycle strobe of R7 within reach.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        CT_SEQ      = 4'd0,
        CT_BR       = 4'd1,
        CT_BSR      = 4'd2,
        CT_JMP      = 4'd3,
        CT_CALL     = 4'd4,
        CT_RET_OUT  = 4'd5,
        CT_RET_IN   = 4'd6,
        CT_SKP_ZERO = 4'd7,
        CT_SKP_NZ   = 4'd8,
        CT_SKP_CC   = 4'd9,
        CT_SKP_NCC  = 4'd10
    } npc_ctrl_e;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } npc_state_e;

endpackage

// File: rtl/npc_rel_target.sv
module npc_rel_target #(
    parameter int PC_W  = 32,
    parameter int OFF_W = 11
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PC_W-1:0]  tgt_o
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] off_plus;

    always_comb begin
        off_ext  = {{EXT_W{off_i[OFF_W-1]}}, off_i};
        off_plus = off_ext + PC_W'(1);
        tgt_o    = pc_i + {off_plus[PC_W-2:0], 1'b0};
    end
endmodule

// File: rtl/npc_skip_eval.sv
module npc_skip_eval #(
    parameter int PC_W = 32
) (
    input  npc_pkg::npc_ctrl_e ctrl_i,
    input  logic [PC_W-1:0]    rs_val_i,
    input  logic               cc_true_i,
    input  logic               next_is_prefix_i,
    output logic [2:0]         adv_o
);
    import npc_pkg::*;

    logic rs_zero;
    logic taken;

    always_comb begin
        rs_zero = (rs_val_i == '0);
        unique case (ctrl_i)
            CT_SKP_ZERO: taken = rs_zero;
            CT_SKP_NZ:   taken = !rs_zero;
            CT_SKP_CC:   taken = cc_true_i;
            CT_SKP_NCC:  taken = !cc_true_i;
            default:     taken = 1'b0;
        endcase
        if (!taken)
            adv_o = 3'd2;
        else if (next_is_prefix_i)
            adv_o = 3'd6;
        else
            adv_o = 3'd4;
    end
endmodule

// File: rtl/npc_link_calc.sv
module npc_link_calc #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] link_o
);
    logic [PC_W-1:0] ret_addr;

    always_comb begin
        ret_addr = pc_i + PC_W'(4);
        link_o   = {1'b0, ret_addr[PC_W-1:1]};
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int              PC_W     = 32,
    parameter int              OFF_W    = 11,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [3:0]       ctrl_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [PC_W-1:0]  rs_val_i,
    input  logic [PC_W-1:0]  olink_i,
    input  logic [PC_W-1:0]  ilink_i,
    input  logic             cc_true_i,
    input  logic             next_is_prefix_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  next_pc_o,
    output logic             link_we_o,
    output logic [PC_W-1:0]  link_val_o
);
    import npc_pkg::*;

    localparam logic [PC_W-1:0] RESET_PC_AL = {RESET_PC[PC_W-1:1], 1'b0};

    npc_state_e      state_q, state_d;
    npc_ctrl_e       ctrl;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] link_calc;
    logic [2:0]      adv;
    logic [PC_W-1:0] next_pc;
    logic            is_link;
    logic            link_we_q;
    logic [PC_W-1:0] link_val_q;

    assign ctrl = npc_ctrl_e'(ctrl_i);

    npc_rel_target #(.PC_W(PC_W), .OFF_W(OFF_W)) rel_i (
        .pc_i  (pc_q),
        .off_i (offset_i),
        .tgt_o (rel_tgt)
    );

    npc_skip_eval #(.PC_W(PC_W)) skip_i (
        .ctrl_i           (ctrl),
        .rs_val_i         (rs_val_i),
        .cc_true_i        (cc_true_i),
        .next_is_prefix_i (next_is_prefix_i),
        .adv_o            (adv)
    );

    npc_link_calc #(.PC_W(PC_W)) link_i (
        .pc_i   (pc_q),
        .link_o (link_calc)
    );

    // next-address selection
    always_comb begin
        is_link = 1'b0;
        unique case (ctrl)
            CT_BR:      next_pc = rel_tgt;
            CT_BSR: begin
                next_pc = rel_tgt;
                is_link = 1'b1;
            end
            CT_JMP:     next_pc = {rs_val_i[PC_W-2:0], 1'b0};
            CT_CALL: begin
                next_pc = {rs_val_i[PC_W-2:0], 1'b0};
                is_link = 1'b1;
            end
            CT_RET_OUT: next_pc = {olink_i[PC_W-2:0], 1'b0};
            CT_RET_IN:  next_pc = {ilink_i[PC_W-2:0], 1'b0};
            default:    next_pc = pc_q + PC_W'(adv);
        endcase
    end

    // state transitions: boot_done (ST_BOOT -> ST_RUN), stay (ST_RUN)
    always_comb begin
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            state_q <= ST_BOOT;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pc_q       <= RESET_PC_AL;
            link_we_q  <= 1'b0;
            link_val_q <= '0;
        end else begin
            link_we_q <= 1'b0;
            unique case (state_q)
                ST_BOOT: begin
                    pc_q <= RESET_PC_AL;
                end
                ST_RUN: begin
                    if (step_i) begin
                        pc_q <= next_pc;
                        if (is_link) begin
                            link_we_q  <= 1'b1;
                            link_val_q <= link_calc;
                        end
                    end
                end
                default: pc_q <= RESET_PC_AL;
            endcase
        end
    end

    assign pc_o       = pc_q;
    assign next_pc_o  = next_pc;
    assign link_we_o  = link_we_q;
    assign link_val_o = link_val_q;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                step_i,
    input logic [3:0]          ctrl_i,
    input logic [PC_W-1:0]     rs_val_i,
    input logic [PC_W-1:0]     pc_o,
    input logic [PC_W-1:0]     next_pc_o,
    input logic                link_we_o,
    input logic [PC_W-1:0]     link_val_o,
    input npc_pkg::npc_state_e state_q
);
    import npc_pkg::*;

    // R9
    pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_o[0] == 1'b0);

    // R1
    boot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BOOT) |=> (pc_o == {RESET_PC[PC_W-1:1], 1'b0}));

    // R2
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i |=> $stable(pc_o));

    // R2
    seq_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && step_i && ctrl_i == 4'd0) |=> (pc_o == $past(pc_o) + PC_W'(2)));

    // R5
    jmp_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && step_i && ctrl_i == 4'd3) |=> (pc_o == {$past(rs_val_i[PC_W-2:0]), 1'b0}));

    // R3
    step_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && step_i) |=> (pc_o == $past(next_pc_o)));

    // R7
    link_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> $past(state_q == ST_RUN && step_i && (ctrl_i == 4'd2 || ctrl_i == 4'd4)));

    // R7
    link_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> (link_val_o == ((PC_W'($past(pc_o) + PC_W'(4))) >> 1)));

endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .RESET_PC(RESET_PC)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .ctrl_i     (ctrl_i),
    .rs_val_i   (rs_val_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .state_q    (state_q)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
    localparam int          PC_W  = 32;
    localparam int          OFF_W = 11;
    localparam logic [31:0] RST_V = 32'h0000_0040;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             step = 1'b0;
    logic [3:0]       ctrl = '0;
    logic [OFF_W-1:0] off = '0;
    logic [PC_W-1:0]  rs = '0;
    logic [PC_W-1:0]  ol = '0;
    logic [PC_W-1:0]  il = '0;
    logic             cc = 1'b0;
    logic             pf = 1'b0;
    logic [PC_W-1:0]  pc_o, next_pc_o, link_val_o;
    logic             link_we_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_unit #(.PC_W(PC_W), .OFF_W(OFF_W), .RESET_PC(RST_V)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .step_i(step), .ctrl_i(ctrl),
        .offset_i(off), .rs_val_i(rs), .olink_i(ol), .ilink_i(il),
        .cc_true_i(cc), .next_is_prefix_i(pf), .pc_o(pc_o),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_val_o(link_val_o)
    );

    typedef struct {
        logic [31:0] pc;
        logic        lwe;
        logic [31:0] lval;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] m_pc;
    bit          m_run;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: caller is just after a falling edge
    task automatic drive(input logic st, input logic [3:0] c, input logic [10:0] o,
                         input logic [31:0] r, input logic [31:0] olv, input logic [31:0] ilv,
                         input logic cv, input logic pv, input string tag);
        exp_t        e;
        logic [31:0] sx;
        logic [2:0]  adv;
        logic        tk;
        step = st; ctrl = c; off = o; rs = r; ol = olv; il = ilv; cc = cv; pf = pv;
        e.pc = m_pc; e.lwe = 1'b0; e.lval = 32'h0; e.tag = tag;
        if (st && m_run) begin
            sx = {{21{o[10]}}, o};
            tk = 1'b0;
            case (c)
                4'd7:  tk = (r == 0);
                4'd8:  tk = (r != 0);
                4'd9:  tk = cv;
                4'd10: tk = !cv;
                default: tk = 1'b0;
            endcase
            adv = !tk ? 3'd2 : (pv ? 3'd6 : 3'd4);
            case (c)
                4'd1, 4'd2: e.pc = m_pc + ((sx + 32'd1) << 1);
                4'd3, 4'd4: e.pc = r << 1;
                4'd5:       e.pc = olv << 1;
                4'd6:       e.pc = ilv << 1;
                default:    e.pc = m_pc + 32'(adv);
            endcase
            if (c == 4'd2 || c == 4'd4) begin
                e.lwe  = 1'b1;
                e.lval = (m_pc + 32'd4) >> 1;
            end
        end
        @(posedge clk);
        #1;
        sb_q.push_back(e);
        m_pc  = e.pc;
        m_run = 1'b1;
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " pc"}, pc_o, e.pc);
            check({e.tag, " link_we"}, 32'(link_we_o), 32'(e.lwe));
            if (e.lwe)
                check({e.tag, " link_val"}, link_val_o, e.lval);
            check("R9 pc even", 32'(pc_o[0]), 32'h0);
        end
    end

    initial begin
        m_pc  = RST_V;
        m_run = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pc", pc_o, RST_V);
        check("R1 reset link_we", 32'(link_we_o), 32'h0);
        rst_n = 1'b1;
        // R1: step during boot cycle ignored
        drive(1, 4'd1, 11'd20, 0, 0, 0, 0, 0, "R1 boot ignore");
        drive(1, 4'd0, 11'd0, 0, 0, 0, 0, 0, "R2 seq");
        drive(0, 4'd0, 11'd0, 0, 0, 0, 0, 0, "R2 idle hold");
        drive(0, 4'd3, 11'd0, 32'h5555, 0, 0, 0, 0, "R2 idle ignores jump");
        drive(1, 4'd15, 11'd0, 0, 0, 0, 0, 0, "R2 undefined code");
        drive(1, 4'd1, 11'd5, 0, 0, 0, 0, 0, "R3 fwd branch");
        drive(1, 4'd1, 11'h7FF, 0, 0, 0, 0, 0, "R3 offset minus one");
        drive(1, 4'd1, 11'h400, 0, 0, 0, 0, 0, "R3 max backward wrap");
        drive(1, 4'd1, 11'h3FF, 0, 0, 0, 0, 0, "R3 max forward");
        drive(1, 4'd2, 11'd3, 0, 0, 0, 0, 0, "R4 bsr");
        drive(0, 4'd0, 11'd0, 0, 0, 0, 0, 0, "R7 strobe one cycle");
        drive(1, 4'd3, 11'd0, 32'h0000_1234, 0, 0, 0, 0, "R5 jmp");
        drive(1, 4'd4, 11'd0, 32'h8000_0081, 0, 0, 0, 0, "R5 call top bit");
        drive(1, 4'd4, 11'd0, 32'h7FFF_FFFF, 0, 0, 0, 0, "R7 back-to-back call");
        drive(1, 4'd2, 11'h7FE, 0, 0, 0, 0, 0, "R7 call near top then bsr");
        drive(1, 4'd0, 11'd0, 0, 0, 0, 0, 0, "R7 seq no link");
        drive(1, 4'd5, 11'd0, 0, 32'h0000_0300, 32'h0000_0900, 0, 0, "R6 ret out");
        drive(1, 4'd6, 11'd0, 0, 32'h0000_0300, 32'h0000_0900, 0, 0, "R6 ret in");
        drive(1, 4'd7, 11'd0, 32'h0, 0, 0, 0, 0, "R8 skip zero taken");
        drive(1, 4'd7, 11'd0, 32'h0, 0, 0, 0, 1, "R8 skip zero prefix");
        drive(1, 4'd7, 11'd0, 32'h5, 0, 0, 0, 1, "R8 skip zero not taken");
        drive(1, 4'd8, 11'd0, 32'h5, 0, 0, 0, 1, "R8 skip nz prefix");
        drive(1, 4'd8, 11'd0, 32'h0, 0, 0, 0, 0, "R8 skip nz not taken");
        drive(1, 4'd9, 11'd0, 0, 0, 0, 1, 0, "R8 skip cc taken");
        drive(1, 4'd9, 11'd0, 0, 0, 0, 0, 1, "R8 skip cc not taken");
        drive(1, 4'd10, 11'd0, 0, 0, 0, 1, 1, "R8 skip ncc not taken");
        drive(1, 4'd10, 11'd0, 0, 0, 0, 0, 1, "R8 skip ncc prefix");
        drive(1, 4'd0, 11'd0, 0, 0, 0, 0, 1, "R2 seq ignores prefix");
        drive(0, 4'd0, 11'd0, 0, 0, 0, 0, 0, "R2 final idle");
        wait (sb_q.size() == 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule